// File: doc/BRIEF.md
# DMA Request Ready Generator

This block drives the two active-low DMA request pins of one serial channel: a transmit-ready request and a receive-ready request. It watches the free space of the transmit FIFO and the fill of the receive FIFO. It compares them against programmed trigger levels. It also watches a receive timeout indication and a flag that says an errored character is sitting in the receive FIFO. From these it decides, once per clock, whether a DMA engine should move data.

Two signalling styles exist. In single-character style, a request simply follows the buffer state. Receive requests while any character is waiting. Transmit requests while the transmit side is completely empty. In block style, each request is set at a trigger point and held until the opposite extreme. The transmit request holds until the FIFO is full. The receive request holds until the FIFO is empty or an error is flagged. This lets a DMA engine move many characters per request. Block style is used only when the FIFOs are enabled and the style bit is set.

Top module: `dmr_ready_gen`

## Requirements
- R1: While reset is high at a rising edge, both outputs are high (inactive) after that edge.
- R2: Block style is in force only when fifo_en=1 and blk_sel=1. With fifo_en=0, blk_sel has no effect and single-character style applies.
- R3: In single-character style, rxrdy_n is low exactly when rx_fill was nonzero at the previous edge.
- R4: In single-character style, txrdy_n is low when the transmit side was empty at the previous edge. With fifo_en=1, empty means tx_free equals DEPTH. With fifo_en=0, empty means tx_free is nonzero (the one-byte holding register is free).
- R5: In block style, txrdy_n goes low after an edge where tx_free is nonzero and tx_free >= tx_trig.
- R6: In block style, txrdy_n goes high after an edge where tx_free is 0. This clear takes priority even when tx_trig is 0.
- R7: In block style, rxrdy_n goes low after an edge where rx_fill >= rx_trig, provided no clear condition holds.
- R8: In block style, rxrdy_n goes low after an edge where rx_timeout is high, provided no clear condition holds.
- R9: In block style, rxrdy_n goes high after an edge where rx_fill is 0 or rx_err is high. These clear conditions win over the set conditions.
- R10: In block style, when neither the set nor the clear condition of a request holds, that request keeps its previous level.
- R11: Both outputs come from registers. An input change shows up only after the next rising edge, never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFOs enabled |
| blk_sel | input | 1 | Selects block signalling style (when FIFOs enabled) |
| tx_free | input | CW | Free entries in the transmit FIFO (0..DEPTH) |
| tx_trig | input | CW | Transmit trigger level, in free entries |
| rx_fill | input | CW | Filled entries in the receive FIFO (0..DEPTH) |
| rx_trig | input | CW | Receive trigger level, in filled entries |
| rx_timeout | input | 1 | Receive timeout indication |
| rx_err | input | 1 | An errored character is present in the receive FIFO |
| txrdy_n | output | 1 | Transmit DMA request, active low |
| rxrdy_n | output | 1 | Receive DMA request, active low |

CW is $clog2(DEPTH+1).

## Verification
The bench builds the block with DEPTH=16, which makes the count width 5 bits. With this depth the full, empty and trigger extremes are small numbers, so each can be driven directly. Trigger levels of 0 and of values between the extremes let the bench reach the cases where set and clear conditions overlap. These cases show that the clear wins. Mid-range counts show that the request holds its level. Running with fifo_en low at the same depth shows that the block-style bit is ignored, and that the one-byte notion of an empty transmitter applies.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
  typedef enum logic {
    SIG_SINGLE = 1'b0,
    SIG_BLOCK  = 1'b1
  } sig_mode_e;
endpackage

// File: rtl/dmr_mode_sel.sv
module dmr_mode_sel
  import dmr_pkg::*;
(
  input  logic      fifo_en,
  input  logic      blk_sel,
  output sig_mode_e mode
);
  // Block style requires the FIFOs to be enabled (R2)
  assign mode = (fifo_en && blk_sel) ? SIG_BLOCK : SIG_SINGLE;
endmodule

// File: rtl/dmr_tx_req.sv
module dmr_tx_req
  import dmr_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  sig_mode_e     mode,
  input  logic          fifo_en,
  input  logic [CW-1:0] tx_free,
  input  logic [CW-1:0] tx_trig,
  output logic          act
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic full_c, empty_c, set_c, act_nx;

  assign full_c  = (tx_free == '0);
  assign empty_c = fifo_en ? (tx_free == CAP) : !full_c;
  assign set_c   = !full_c && (tx_free >= tx_trig);

  always_comb begin
    act_nx = act;
    if (mode == SIG_SINGLE) begin
      act_nx = empty_c;
    end else if (full_c) begin
      act_nx = 1'b0;
    end else if (set_c) begin
      act_nx = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) act <= 1'b0;
    else     act <= act_nx;
  end

  // R4: single style follows the empty state of the transmit side
  assert_tx_single_empty_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == SIG_SINGLE && fifo_en && tx_free == CAP) |=> act);
  // R5: block style sets at the trigger level
  assert_tx_block_set_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == SIG_BLOCK && tx_free != '0 && tx_free >= tx_trig) |=> act);
  // R6: block style clears on a full FIFO
  assert_tx_block_full_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == SIG_BLOCK && tx_free == '0) |=> !act);
  // R10: block style holds between events
  assert_tx_block_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mode == SIG_BLOCK && tx_free != '0 && tx_free < tx_trig) |=> $stable(act));
endmodule

// File: rtl/dmr_rx_req.sv
module dmr_rx_req
  import dmr_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  sig_mode_e     mode,
  input  logic [CW-1:0] rx_fill,
  input  logic [CW-1:0] rx_trig,
  input  logic          rx_timeout,
  input  logic          rx_err,
  output logic          act
);
  logic empty_c, clr_c, set_c, act_nx;

  assign empty_c = (rx_fill == '0);
  assign clr_c   = empty_c || rx_err;
  assign set_c   = (rx_fill >= rx_trig) || rx_timeout;

  always_comb begin
    act_nx = act;
    if (mode == SIG_SINGLE) begin
      act_nx = !empty_c;
    end else if (clr_c) begin
      act_nx = 1'b0;
    end else if (set_c) begin
      act_nx = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) act <= 1'b0;
    else     act <= act_nx;
  end

  // R3: single style requests while any character waits
  assert_rx_single_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == SIG_SINGLE && rx_fill != '0) |=> act);
  // R7: block style sets at the trigger level
  assert_rx_block_trig_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == SIG_BLOCK && !rx_err && rx_fill != '0 && rx_fill >= rx_trig) |=> act);
  // R8: block style sets on timeout
  assert_rx_block_tmo_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == SIG_BLOCK && !rx_err && rx_fill != '0 && rx_timeout) |=> act);
  // R9: block style clears on empty or error
  assert_rx_block_clr_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == SIG_BLOCK && (rx_fill == '0 || rx_err)) |=> !act);
  // R10: block style holds between events
  assert_rx_block_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mode == SIG_BLOCK && !rx_err && rx_fill != '0 && rx_fill < rx_trig && !rx_timeout)
      |=> $stable(act));
endmodule

// File: rtl/dmr_ready_gen.sv
module dmr_ready_gen
  import dmr_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          blk_sel,
  input  logic [CW-1:0] tx_free,
  input  logic [CW-1:0] tx_trig,
  input  logic [CW-1:0] rx_fill,
  input  logic [CW-1:0] rx_trig,
  input  logic          rx_timeout,
  input  logic          rx_err,
  output logic          txrdy_n,
  output logic          rxrdy_n
);
  sig_mode_e mode;
  logic      tx_act, rx_act;

  dmr_mode_sel u_mode (
    .fifo_en (fifo_en),
    .blk_sel (blk_sel),
    .mode    (mode)
  );

  dmr_tx_req #(.DEPTH(DEPTH), .CW(CW)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .fifo_en (fifo_en),
    .tx_free (tx_free),
    .tx_trig (tx_trig),
    .act     (tx_act)
  );

  dmr_rx_req #(.DEPTH(DEPTH), .CW(CW)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .rx_fill    (rx_fill),
    .rx_trig    (rx_trig),
    .rx_timeout (rx_timeout),
    .rx_err     (rx_err),
    .act        (rx_act)
  );

  // Pins are straight inversions of flop outputs: no glitch path (R11)
  assign txrdy_n = !tx_act;
  assign rxrdy_n = !rx_act;

  // R1: reset leaves both requests inactive
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (txrdy_n && rxrdy_n));
  // R2: with FIFOs off, a waiting character requests regardless of blk_sel
  assert_fifo_off_single_R2: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && rx_fill != '0) |=> !rxrdy_n);
endmodule

// File: tb/test_dmr_ready_gen.sv
module test_dmr_ready_gen;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fifo_en = 1'b0, blk_sel = 1'b0;
  logic [CW-1:0] tx_free = '0, tx_trig = '0, rx_fill = '0, rx_trig = '0;
  logic          rx_timeout = 1'b0, rx_err = 1'b0;
  logic          txrdy_n, rxrdy_n;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dmr_ready_gen #(.DEPTH(DEPTH)) i_dmr_ready_gen (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .blk_sel(blk_sel),
    .tx_free(tx_free), .tx_trig(tx_trig), .rx_fill(rx_fill), .rx_trig(rx_trig),
    .rx_timeout(rx_timeout), .rx_err(rx_err), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one rising edge passes; sampling at the following falling edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; fifo_en = 1'b1; blk_sel = 1'b0;
    rx_fill = 5'd3; tx_free = 5'(DEPTH);
    step(); step();
    chk("R1 txrdy_n in reset", txrdy_n, 1'b1);
    chk("R1 rxrdy_n in reset", rxrdy_n, 1'b1);
    rst = 1'b0;
    step();
    chk("R3 rx after reset release", rxrdy_n, 1'b0);
    chk("R4 tx after reset release", txrdy_n, 1'b0);
  endtask

  task automatic t_single();
    fifo_en = 1'b1; blk_sel = 1'b0;
    rx_fill = '0; tx_free = 5'd15;
    step();
    chk("R3 rx empty", rxrdy_n, 1'b1);
    chk("R4 tx not empty", txrdy_n, 1'b1);
    rx_fill = 5'd1; tx_free = 5'(DEPTH);
    #1;
    chk("R11 rx unchanged before edge", rxrdy_n, 1'b1);
    chk("R11 tx unchanged before edge", txrdy_n, 1'b1);
    step();
    chk("R3 rx one char", rxrdy_n, 1'b0);
    chk("R4 tx empty", txrdy_n, 1'b0);
  endtask

  task automatic t_fifo_off();
    fifo_en = 1'b0; blk_sel = 1'b1;
    rx_trig = 5'd8; rx_fill = 5'd3; tx_free = 5'd1; tx_trig = 5'd8;
    step();
    chk("R2 rx single with fifo off", rxrdy_n, 1'b0);
    chk("R4 tx holding reg free", txrdy_n, 1'b0);
    rx_err = 1'b1; tx_free = '0;
    step();
    chk("R2 error ignored with fifo off", rxrdy_n, 1'b0);
    chk("R4 tx holding reg busy", txrdy_n, 1'b1);
    rx_err = 1'b0; rx_fill = '0;
    step();
    chk("R2 rx idle with fifo off", rxrdy_n, 1'b1);
  endtask

  task automatic t_block_tx();
    fifo_en = 1'b1; blk_sel = 1'b1; tx_trig = 5'd8;
    tx_free = '0; step();
    chk("R6 full clears", txrdy_n, 1'b1);
    tx_free = 5'd4; step();
    chk("R10 tx holds inactive", txrdy_n, 1'b1);
    tx_free = 5'd8; step();
    chk("R5 trigger sets", txrdy_n, 1'b0);
    tx_free = 5'd3; step();
    chk("R10 tx holds active", txrdy_n, 1'b0);
    tx_free = '0; step();
    chk("R6 full clears again", txrdy_n, 1'b1);
    tx_trig = '0; step();
    chk("R6 full wins over zero trigger", txrdy_n, 1'b1);
    tx_free = 5'd1; step();
    chk("R5 zero trigger sets", txrdy_n, 1'b0);
  endtask

  task automatic t_block_rx();
    fifo_en = 1'b1; blk_sel = 1'b1; rx_trig = 5'd8;
    rx_fill = '0; rx_timeout = 1'b0; rx_err = 1'b0; step();
    chk("R9 empty clears", rxrdy_n, 1'b1);
    rx_fill = 5'd5; step();
    chk("R10 rx holds inactive", rxrdy_n, 1'b1);
    rx_fill = 5'd8; step();
    chk("R7 trigger sets", rxrdy_n, 1'b0);
    rx_fill = 5'd2; step();
    chk("R10 rx holds active", rxrdy_n, 1'b0);
    rx_fill = '0; step();
    chk("R9 empty clears again", rxrdy_n, 1'b1);
    rx_fill = 5'd3; rx_timeout = 1'b1; step();
    chk("R8 timeout sets", rxrdy_n, 1'b0);
    rx_timeout = 1'b0; step();
    chk("R10 rx holds after timeout", rxrdy_n, 1'b0);
    rx_err = 1'b1; step();
    chk("R9 error clears", rxrdy_n, 1'b1);
    rx_err = 1'b0; step();
    chk("R10 rx holds after error", rxrdy_n, 1'b1);
    rx_fill = '0; rx_timeout = 1'b1; step();
    chk("R9 empty wins over timeout", rxrdy_n, 1'b1);
    rx_timeout = 1'b0; rx_fill = 5'd9; rx_err = 1'b1; step();
    chk("R9 error wins over trigger", rxrdy_n, 1'b1);
    rx_err = 1'b0; step();
    chk("R7 trigger sets after error gone", rxrdy_n, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    step();
    t_reset();
    t_single();
    t_fifo_off();
    t_block_tx();
    t_block_rx();
    finish_run();
  end
endmodule